// File: doc/BRIEF.md
# Dual Trimmed Slow-Clock Match Counter

Two independent 32-bit counters run in a slow clock domain, nominally 32.768 kHz. Software programs them from a fast register bus. Each counter has a 16-bit prescaler ("trim") that can be bypassed, a load register, a bus-visible copy of the running count, and three compare registers. When the count steps onto a compare value, the matching compare register raises a one-cycle interrupt pulse in the bus domain.

The slow clock comes either from the oscillator input or from an external clock pin. Bit 14 of the control word selects between them. An oscillator-enable bit drives an output to the oscillator, and a status bit reports that the slow domain is clocking.

Each bus write to a slow-side register travels through a toggle handshake. Every writable register has its own pending bit in the control word. Software must poll that bit before it writes the same register again, because a write made while the bit is set is dropped.

Top module: `pc_dual_counter`

## Requirements
- R1: After reset, the control word, all register copies and the count readback all read 0, `irq_o` is 0 and `osc_en_o` is 0.
- R2: An accepted write sets that register's pending bit on the next bus cycle, and the bit clears without further action. A write to a register whose pending bit is set leaves its readback unchanged. The counter 0 pending bits are: 0 load, 1 to 3 compare 0 to 2, 4 trim, 7 enable. Counter 1 uses the same layout shifted by 16.
- R3: When trim is not bypassed, the counter advances once every trim+1 slow clocks.
- R4: When the trim-bypass bit is set (bit 10 for counter 0, bit 12 for counter 1), the counter advances on every slow clock.
- R5: A value written to the load offset (0x04 or 0x48) replaces the count. After the read path settles, that value is returned at the readback offset (0x40 or 0x58).
- R6: The count wraps from 0xFFFFFFFF to 0 and carries on counting.
- R7: A compare interrupt is a single bus-cycle pulse. Each step of the count onto that compare value gives exactly one pulse. The compare registers of counter 0 sit at 0x08, 0x0C and 0x10 and drive `irq_o[0..2]`.
- R8: With its enable bit clear (bit 11 or bit 13), a counter holds its value and raises no compare pulse.
- R9: Counter 1 uses offsets 0x44 (trim), 0x48 (load), 0x4C/0x50/0x54 (compares) and 0x58 (readback), and drives `irq_o[3..5]` without affecting counter 0.
- R10: Control bit 14 moves the slow domain onto `ext_clk_i`.
- R11: Control bit 8 drives `osc_en_o`. Control bit 5 reads 1 once the oscillator is enabled and the slow domain has clocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | bus clock |
| rst_ni | input | 1 | active-low asynchronous reset, both domains |
| osc_clk_i | input | 1 | oscillator clock |
| ext_clk_i | input | 1 | external slow clock |
| osc_en_o | output | 1 | oscillator enable |
| wr_i | input | 1 | register write strobe |
| addr_i | input | 7 | register byte offset |
| wdata_i | input | 32 | write data |
| rdata_o | output | 32 | read data for addr_i (combinational) |
| irq_o | output | 6 | compare pulses, counter*3 + compare index |

## Verification
The hardest case to reach is the exact spacing of count steps, because every slow-domain event reaches the ports only after a synchroniser. The bench loads two compare registers a known distance apart. It counts slow-clock edges between the two resulting pulses; both pulses cross the same synchroniser, so the latency cancels. It sweeps the trim value and the bypass modes this way, and places the compares across the all-ones boundary to reach the wrap. Dropped writes are produced by writing a register twice in back-to-back bus cycles.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int CW  = 32;  // counter and bus width
  localparam int TW  = 16;  // trim width
  localparam int NM  = 3;   // compares per counter
  localparam int NCH = 2;
  localparam int AW  = 7;

  localparam int B_OSC_STAT = 5;
  localparam int B_OSC_EN   = 8;
  localparam int B_OSC_BYP  = 14;
  localparam logic [AW-1:0] OFF_CTRL = AW'(8'h14);

  function automatic int b_bt(input int ch);  return ch != 0 ? 12 : 10; endfunction
  function automatic int b_en(input int ch);  return ch != 0 ? 13 : 11; endfunction
  function automatic int stat_lsb(input int ch); return 16 * ch; endfunction

  function automatic logic [AW-1:0] off_trim(input int ch);
    return ch != 0 ? AW'(8'h44) : AW'(8'h00);
  endfunction
  function automatic logic [AW-1:0] off_load(input int ch);
    return ch != 0 ? AW'(8'h48) : AW'(8'h04);
  endfunction
  function automatic logic [AW-1:0] off_cmp(input int ch, input int k);
    return AW'((ch != 0 ? 8'h4C : 8'h08) + 4 * k);
  endfunction
  function automatic logic [AW-1:0] off_rd(input int ch);
    return ch != 0 ? AW'(8'h58) : AW'(8'h40);
  endfunction
endpackage

// File: rtl/pc_xfer.sv
// Bus-to-slow register transfer: hold copy, toggle request, synchronised ack.
module pc_xfer #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sclk_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         busy_o,
  output logic [W-1:0] hold_o,
  output logic [W-1:0] sval_o,
  output logic         sld_o
);
  logic req_q, ack_m, ack_q;
  logic s1_q, s2_q, s3_q;
  logic [W-1:0] hold_q, sval_q;
  logic ld_q;

  assign busy_o = req_q ^ ack_q;
  assign hold_o = hold_q;
  assign sval_o = sval_q;
  assign sld_o  = ld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0; ack_m <= 1'b0; ack_q <= 1'b0; hold_q <= '0;
    end else begin
      ack_m <= s2_q;
      ack_q <= ack_m;
      if (wr_i && !busy_o) begin
        hold_q <= wdata_i;
        req_q  <= ~req_q;
      end
    end
  end

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0; s2_q <= 1'b0; s3_q <= 1'b0; ld_q <= 1'b0; sval_q <= '0;
    end else begin
      s1_q <= req_q;
      s2_q <= s1_q;
      s3_q <= s2_q;
      ld_q <= s2_q ^ s3_q;
      if (s2_q ^ s3_q) sval_q <= hold_q;
    end
  end

  a_r2_pending_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !busy_o |=> busy_o);
  a_r2_drop_while_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(hold_q));
endmodule

// File: rtl/pc_snap.sv
// Untorn readback: slow side freezes a snapshot until the bus side acknowledges it.
module pc_snap #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sclk_i,
  input  logic [W-1:0] scnt_i,
  output logic [W-1:0] rd_o
);
  logic [W-1:0] snap_q, rd_q;
  logic stog_q, a1_q, a2_q;
  logic b1_q, b2_q, b3_q;

  assign rd_o = rd_q;

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0; stog_q <= 1'b0; a1_q <= 1'b0; a2_q <= 1'b0;
    end else begin
      a1_q <= b2_q;
      a2_q <= a1_q;
      if (a2_q == stog_q) begin
        snap_q <= scnt_i;
        stog_q <= ~stog_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b1_q <= 1'b0; b2_q <= 1'b0; b3_q <= 1'b0; rd_q <= '0;
    end else begin
      b1_q <= stog_q;
      b2_q <= b1_q;
      b3_q <= b2_q;
      if (b2_q ^ b3_q) rd_q <= snap_q;
    end
  end

  a_r5_snap_frozen: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (a2_q != stog_q) |=> $stable(snap_q));
endmodule

// File: rtl/pc_chan.sv
module pc_chan
  import pc_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] wdata_i,
  output logic          en_o,
  output logic          bt_o,
  output logic [7:0]    stat_o,
  output logic [CW-1:0] rdata_o,
  output logic [NM-1:0] irq_o
);
  logic ctrl_we;
  logic [1:0] enbt_hold, enbt_s;
  logic enbt_busy, enbt_ld;
  logic [TW-1:0] trim_hold, trim_s;
  logic trim_busy, trim_ld;
  logic [CW-1:0] load_hold, load_s, rd_val;
  logic load_busy, load_ld;
  logic [CW-1:0] cmp_hold [NM];
  logic [CW-1:0] cmp_s [NM];
  logic [NM-1:0] cmp_busy, cmp_ld;

  logic [TW-1:0] pre_q;
  logic [CW-1:0] cnt_q, nxt;
  logic tick, en_s, bt_s;

  assign ctrl_we = wr_i && addr_i == OFF_CTRL;

  pc_xfer #(.W(2)) u_enbt (
    .clk_i, .rst_ni, .sclk_i, .wr_i(ctrl_we),
    .wdata_i({wdata_i[b_en(CH)], wdata_i[b_bt(CH)]}),
    .busy_o(enbt_busy), .hold_o(enbt_hold), .sval_o(enbt_s), .sld_o(enbt_ld));

  pc_xfer #(.W(TW)) u_trim (
    .clk_i, .rst_ni, .sclk_i, .wr_i(wr_i && addr_i == off_trim(CH)),
    .wdata_i(wdata_i[TW-1:0]),
    .busy_o(trim_busy), .hold_o(trim_hold), .sval_o(trim_s), .sld_o(trim_ld));

  pc_xfer #(.W(CW)) u_load (
    .clk_i, .rst_ni, .sclk_i, .wr_i(wr_i && addr_i == off_load(CH)),
    .wdata_i(wdata_i),
    .busy_o(load_busy), .hold_o(load_hold), .sval_o(load_s), .sld_o(load_ld));

  assign en_s = enbt_s[1];
  assign bt_s = enbt_s[0];
  assign en_o = enbt_hold[1];
  assign bt_o = enbt_hold[0];
  assign nxt  = cnt_q + 1'b1;
  assign tick = en_s && (bt_s || pre_q >= trim_s);

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      if (!en_s || tick || load_ld) pre_q <= '0;
      else                          pre_q <= pre_q + 1'b1;
      if (load_ld)   cnt_q <= load_s;
      else if (tick) cnt_q <= nxt;
    end
  end

  for (genvar k = 0; k < NM; k++) begin : g_cmp
    logic mtog_q, m1_q, m2_q, m3_q, irq_q;

    pc_xfer #(.W(CW)) u_cmp (
      .clk_i, .rst_ni, .sclk_i, .wr_i(wr_i && addr_i == off_cmp(CH, k)),
      .wdata_i(wdata_i),
      .busy_o(cmp_busy[k]), .hold_o(cmp_hold[k]), .sval_o(cmp_s[k]), .sld_o(cmp_ld[k]));

    always_ff @(posedge sclk_i or negedge rst_ni) begin
      if (!rst_ni)                                    mtog_q <= 1'b0;
      else if (tick && !load_ld && nxt == cmp_s[k]) mtog_q <= ~mtog_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        m1_q <= 1'b0; m2_q <= 1'b0; m3_q <= 1'b0; irq_q <= 1'b0;
      end else begin
        m1_q  <= mtog_q;
        m2_q  <= m1_q;
        m3_q  <= m2_q;
        irq_q <= m2_q ^ m3_q;
      end
    end
    assign irq_o[k] = irq_q;

    a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_q |=> !irq_q);
  end

  pc_snap #(.W(CW)) u_snap (.clk_i, .rst_ni, .sclk_i, .scnt_i(cnt_q), .rd_o(rd_val));

  always_comb begin
    stat_o    = '0;
    stat_o[0] = load_busy;
    stat_o[3:1] = cmp_busy;
    stat_o[4] = trim_busy;
    stat_o[7] = enbt_busy;
    rdata_o   = '0;
    if (addr_i == off_trim(CH)) rdata_o = CW'(trim_hold);
    if (addr_i == off_load(CH)) rdata_o = load_hold;
    if (addr_i == off_rd(CH))   rdata_o = rd_val;
    for (int k = 0; k < NM; k++)
      if (addr_i == off_cmp(CH, k)) rdata_o = cmp_hold[k];
  end

  // enbt_ld and trim_ld are capture strobes that are not needed here.
  logic unused_ld;
  assign unused_ld = enbt_ld ^ trim_ld ^ (^cmp_ld);

  a_r8_hold_when_off: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    !en_s && !load_ld |=> $stable(cnt_q));
  a_r6_wrap_to_zero: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    cnt_q == '1 && tick && !load_ld |=> cnt_q == '0);
endmodule

// File: rtl/pc_dual_counter.sv
module pc_dual_counter
  import pc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 osc_clk_i,
  input  logic                 ext_clk_i,
  output logic                 osc_en_o,
  input  logic                 wr_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [CW-1:0]        wdata_i,
  output logic [CW-1:0]        rdata_o,
  output logic [NCH*NM-1:0]    irq_o
);
  logic osc_en_q, osc_byp_q, sclk;
  logic alive_q, al1_q, al2_q, osc_stat;
  logic [NCH-1:0] en_b, bt_b;
  logic [7:0]     stat [NCH];
  logic [CW-1:0]  ch_rd [NCH];

  // Source switch: software changes it only with both counters idle.
  assign sclk     = osc_byp_q ? ext_clk_i : osc_clk_i;
  assign osc_en_o = osc_en_q;
  assign osc_stat = osc_en_q && al2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_en_q <= 1'b0; osc_byp_q <= 1'b0; al1_q <= 1'b0; al2_q <= 1'b0;
    end else begin
      al1_q <= alive_q;
      al2_q <= al1_q;
      if (wr_i && addr_i == OFF_CTRL) begin
        osc_en_q  <= wdata_i[B_OSC_EN];
        osc_byp_q <= wdata_i[B_OSC_BYP];
      end
    end
  end

  always_ff @(posedge sclk or negedge rst_ni) begin
    if (!rst_ni) alive_q <= 1'b0;
    else         alive_q <= 1'b1;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pc_chan #(.CH(c)) u_ch (
      .clk_i, .rst_ni, .sclk_i(sclk), .wr_i, .addr_i, .wdata_i,
      .en_o(en_b[c]), .bt_o(bt_b[c]), .stat_o(stat[c]), .rdata_o(ch_rd[c]),
      .irq_o(irq_o[c*NM +: NM]));
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFF_CTRL) begin
      for (int c = 0; c < NCH; c++) begin
        rdata_o[stat_lsb(c) +: 8] = stat[c];
        rdata_o[b_en(c)] = en_b[c];
        rdata_o[b_bt(c)] = bt_b[c];
      end
      rdata_o[B_OSC_STAT] = osc_stat;
      rdata_o[B_OSC_EN]   = osc_en_q;
      rdata_o[B_OSC_BYP]  = osc_byp_q;
    end else begin
      for (int c = 0; c < NCH; c++) rdata_o = rdata_o | ch_rd[c];
    end
  end

  a_r11_status_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> !osc_stat);
endmodule

// File: tb/tb_pc_dual_counter.sv
module tb_pc_dual_counter;
  logic clk = 0, osc = 0, ext = 0, rst_n = 0;
  logic wr = 0;
  logic [6:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [5:0] irq;
  logic osc_en;
  int checks = 0, fails = 0;
  int n_osc = 0, n_ext = 0, dbl = 0;
  int np [6];
  int st [6];
  logic [5:0] prv = 0;
  bit use_ext = 0;

  localparam logic [31:0] OSC = 32'h100, BT0 = 32'h400, EN0 = 32'h800;
  localparam logic [31:0] BT1 = 32'h1000, EN1 = 32'h2000, BYP = 32'h4000;
  localparam logic [31:0] PEND = 32'h009F_009F;

  always #4 clk = ~clk;
  always #40 osc = ~osc;
  always #52 ext = ~ext;
  always @(posedge osc) n_osc++;
  always @(posedge ext) n_ext++;

  pc_dual_counter dut (.clk_i(clk), .rst_ni(rst_n), .osc_clk_i(osc), .ext_clk_i(ext),
    .osc_en_o(osc_en), .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  initial for (int k = 0; k < 6; k++) begin np[k] = 0; st[k] = 0; end

  always @(negedge clk) begin
    for (int k = 0; k < 6; k++) if (irq[k]) begin
      np[k]++;
      st[k] = use_ext ? n_ext : n_osc;
      if (prv[k]) dbl++;
    end
    prv = irq;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd_reg(7'h14, v);
      if ((v & PEND) == 0) return;
    end
    chk(0, "R2 pending never cleared", v & PEND, 0);
  endtask

  task automatic slow_wait(input int n);
    repeat (n) @(posedge osc);
  endtask

  // load, arm two compares, enable, and measure slow edges between the pulses
  task automatic run_pair(input int c, input logic [31:0] ctl_base, input logic [31:0] on_bits,
                          input logic [15:0] trim, input logic [31:0] ld,
                          input logic [31:0] ma, input logic [31:0] mb, input logic [31:0] mc,
                          input int exp_diff, input string tag);
    logic [6:0] b;
    int n0, n1, i;
    b = (c != 0) ? 7'h44 : 7'h00;
    wait_idle();
    wr_reg(b, {16'h0, trim});
    wr_reg(b + 7'h04, ld);
    wr_reg(b + 7'h08, ma);
    wr_reg(b + 7'h0C, mb);
    wr_reg(b + 7'h10, mc);
    wait_idle();
    n0 = np[3*c]; n1 = np[3*c+1];
    wr_reg(7'h14, ctl_base | on_bits);
    for (i = 0; i < 20000 && np[3*c+1] == n1; i++) @(negedge clk);
    chk(np[3*c] - n0 == 1, {tag, " first compare pulse count"}, np[3*c] - n0, 1);
    chk(np[3*c+1] - n1 == 1, {tag, " second compare pulse count"}, np[3*c+1] - n1, 1);
    chk(st[3*c+1] - st[3*c] == exp_diff, {tag, " slow edges between compares"},
        st[3*c+1] - st[3*c], exp_diff);
  endtask

  initial begin
    logic [31:0] v, a0;
    int p2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    rd_reg(7'h14, v); chk(v == 0, "R1 control word", v, 0);
    rd_reg(7'h40, v); chk(v == 0, "R1 count readback", v, 0);
    rd_reg(7'h4C, v); chk(v == 0, "R1 compare copy", v, 0);
    chk(irq == 0 && osc_en == 0, "R1 outputs", {26'h0, irq}, 0);

    // R11: oscillator enable and status
    wr_reg(7'h14, OSC);
    chk(osc_en == 1, "R11 osc_en_o", {31'h0, osc_en}, 1);
    slow_wait(10);
    rd_reg(7'h14, v); chk(v[5] == 1, "R11 status bit 5", {31'h0, v[5]}, 1);

    // R2: pending bit and dropped write
    wait_idle();
    wr_reg(7'h00, 32'd5);
    wr_reg(7'h00, 32'd9);
    rd_reg(7'h14, v); chk(v[4] == 1, "R2 trim pending set", {31'h0, v[4]}, 1);
    wait_idle();
    rd_reg(7'h00, v); chk(v == 5, "R2 write while pending dropped", v, 5);
    wr_reg(7'h00, 32'd9); wait_idle();
    rd_reg(7'h00, v); chk(v == 9, "R2 write after clear taken", v, 9);

    // R5: load and untorn readback
    wr_reg(7'h04, 32'h1234_5678); wait_idle(); slow_wait(12);
    rd_reg(7'h40, v); chk(v == 32'h1234_5678, "R5 readback of loaded value", v, 32'h1234_5678);

    // R3: trim sweep on counter 0
    for (int t = 0; t < 4; t++) begin
      run_pair(0, OSC, EN0, 16'(t), 0, 4, 9, 32'h8000_0000, 5 * (t + 1), "R3");
      wait_idle(); wr_reg(7'h14, OSC);
    end
    // R4: bypass ignores trim
    run_pair(0, OSC, EN0 | BT0, 16'd3, 0, 4, 9, 32'h8000_0000, 5, "R4");
    wait_idle(); wr_reg(7'h14, OSC);

    // R6/R7: wrap through all-ones
    p2 = np[2];
    run_pair(0, OSC, EN0 | BT0, 16'd0, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 0, 1, 1, "R6");
    repeat (40) @(negedge clk);
    chk(np[2] - p2 == 1, "R6 compare at 1 after wrap", np[2] - p2, 1);
    chk(st[2] - st[1] == 1, "R6 zero then one", st[2] - st[1], 1);
    wait_idle(); wr_reg(7'h14, OSC); wait_idle();

    // R8: disabled counter holds and never matches
    slow_wait(20);
    rd_reg(7'h40, a0);
    p2 = np[0];
    wr_reg(7'h08, a0 + 1); wait_idle();
    slow_wait(40);
    rd_reg(7'h40, v); chk(v == a0, "R8 count held while disabled", v, a0);
    chk(np[0] == p2, "R8 no compare pulse while disabled", np[0] - p2, 0);

    // R9: counter 1 offsets and independence
    p2 = np[0] + np[1] + np[2];
    run_pair(1, OSC, EN1, 16'd1, 0, 2, 6, 32'h8000_0000, 8, "R9");
    wait_idle(); wr_reg(7'h14, OSC); wait_idle();
    chk(np[0] + np[1] + np[2] == p2, "R9 counter 0 untouched", np[0] + np[1] + np[2] - p2, 0);
    slow_wait(20);
    rd_reg(7'h58, v); chk(v == 6 || v == 7, "R9 readback offset", v, 6);

    // R10: external source
    wr_reg(7'h14, OSC | BYP); use_ext = 1;
    run_pair(1, OSC | BYP, EN1 | BT1, 16'd0, 0, 10, 14, 32'h8000_0000, 4, "R10");
    wait_idle(); wr_reg(7'h14, OSC | BYP); wait_idle();

    chk(dbl == 0, "R7 pulses one cycle wide", dbl, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule